// File: doc/BRIEF.md
# Masked-Write DMA Channel Control Registers

This block holds the control and status state for a group of DMA channels on a 32-bit word-only register bus. Software does not write status bits directly. It writes a control word whose upper half-word selects the bits to change and whose lower half-word gives their new values. The block then applies fixed rules to the run, pause, wake and flush bits. It clears the dead flag when the channel is stopped, and it derives the active flag from the transitions that just took place. The command processor is told through one-cycle start pulses. The attached device receives one-cycle flush pulses.

The channel number and the register index both come from the bus address. The upper address bits above the channel shift select the channel, and the word offset inside that channel's slice selects the register. Each channel has a status word that is read-only, a control word, and a few plain storage words, which typically hold pointers and condition selects for the command processor. A halt input from the command processor marks a channel dead and drops its active flag.

Top module: `chctl_regblock`

## Requirements
- R1: A control write (register index 0) takes its mask from bits 31:16 and its values from bits 15:0. A status bit whose mask bit is 0 stays unchanged, and a control write with an all-zero mask leaves the status at its previous value.
- R2: Status bit positions are run 15, pause 14, flush 13, wake 12, dead 11 and active 10. If the run mask is set with value 1, run is set. If the run mask is set with value 0, both run and dead are cleared.
- R3: The wake bit is set only when its mask is set, its value is 1, and run is set after the run rule of the same write has been applied. Otherwise the write does not set wake.
- R4: When the pause mask is set, the pause status bit takes the written value.
- R5: When the flush mask is set with value 1, the flush status bit is set and flush_req for that channel pulses high for one cycle, in the cycle after the write. When the flush mask is set with value 0, no pulse is produced.
- R6: After the other rules have been applied, active is cleared if pause is set or run is clear. Otherwise active is set if the mask covers run or pause, or if wake is written with value 1. In every other case active keeps its previous value.
- R7: When the resulting active bit is 1 after a control write, start_req for that channel pulses high for one cycle, in the cycle after the write. When the resulting active bit is 0, start_req stays low.
- R8: A halt_req pulse for a channel sets its dead bit and clears its active bit, and leaves the other status bits unchanged.
- R9: Reads return their data on rdata one cycle after rd_en, with rd_valid high in that cycle. Register index 1 returns the status word. Index 0 returns the last control word written. Indices 2 up to REGS_PER_CH-1 return the words last written to them. A write to index 1 is ignored.
- R10: The channel number is addr[11:8] and the register index is addr[7:2]. An access to a channel at or above NUM_CH, or to a register index at or above REGS_PER_CH, is ignored on write and reads as zero.
- R11: Reset clears every status, control and storage word of every channel to zero, and also clears rdata, rd_valid, flush_req and start_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (12) | Byte address within the 4 KB window |
| wdata | input | 32 | Write data |
| halt_req | input | NUM_CH | Per-channel halt from the command processor |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | rdata is valid this cycle |
| flush_req | output | NUM_CH | Per-channel flush pulse to the device |
| start_req | output | NUM_CH | Per-channel start pulse to the command processor |

## Verification
The assertions check the following on every cycle, for every channel:
- active is never set unless run is set and pause is clear.
- wake never rises while run is clear.
- dead only falls in a cycle where run is clear.
- a flush pulse is always accompanied by the flush status bit.
- a start pulse is always accompanied by the active bit.
- a read is always followed by rd_valid.

Some behaviours depend on exact bit values and on what was written before, so only the bench's scenarios can show them. These are the precise status words after each write, the case where active keeps its old value, a write whose mask is empty, a flush written with value 0, the address decode with out-of-range channels and indices, the ignored write to the status word, and the clearing done by reset.

// File: rtl/chctl_pkg.sv
package chctl_pkg;
  // Status bit positions
  localparam int unsigned B_RUN    = 15;
  localparam int unsigned B_PAUSE  = 14;
  localparam int unsigned B_FLUSH  = 13;
  localparam int unsigned B_WAKE   = 12;
  localparam int unsigned B_DEAD   = 11;
  localparam int unsigned B_ACTIVE = 10;

  // Register indices inside one channel slice
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_STATUS = 1;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/chctl_addr_decode.sv
module chctl_addr_decode #(
  parameter int ADDR_W       = 12,
  parameter int CH_SHIFT     = 8,
  parameter int NUM_CH       = 4,
  parameter int REGS_PER_CH  = 8,
  localparam int CH_IDX_W    = ADDR_W - CH_SHIFT,
  localparam int RIDX_W      = CH_SHIFT - 2,
  localparam int CH_SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int REG_SEL_W   = (REGS_PER_CH > 1) ? $clog2(REGS_PER_CH) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [CH_IDX_W-1:0]  ch_idx,
  output logic [CH_SEL_W-1:0]  ch_sel,
  output logic [REG_SEL_W-1:0] reg_sel,
  output logic                 ch_ok,
  output logic                 reg_ok
);
  logic [RIDX_W-1:0] reg_idx;
  logic              unused_lsb;

  assign ch_idx     = addr[ADDR_W-1:CH_SHIFT];
  assign reg_idx    = addr[CH_SHIFT-1:2];
  assign unused_lsb = ^addr[1:0];

  assign ch_sel  = ch_idx[CH_SEL_W-1:0];
  assign reg_sel = reg_idx[REG_SEL_W-1:0];

  assign ch_ok  = ({{(32-CH_IDX_W){1'b0}}, ch_idx} < 32'(NUM_CH));
  assign reg_ok = ({{(32-RIDX_W){1'b0}}, reg_idx} < 32'(REGS_PER_CH));
endmodule

// File: rtl/chctl_status_update.sv
module chctl_status_update
  import chctl_pkg::*;
(
  input  word_t cur,
  input  logic  ctl_we,
  input  word_t ctl,
  input  logic  halt,
  output word_t nxt,
  output logic  flush_p,
  output logic  start_p
);
  logic [HALF_W-1:0] msk;
  logic [HALF_W-1:0] val;
  word_t             s;

  assign msk = ctl[WORD_W-1:HALF_W];
  assign val = ctl[HALF_W-1:0];

  always_comb begin
    s       = cur;
    flush_p = 1'b0;
    if (ctl_we) begin
      // run: set, or clear together with dead
      if (msk[B_RUN] && val[B_RUN]) s[B_RUN] = 1'b1;
      if (msk[B_RUN] && !val[B_RUN]) begin
        s[B_RUN]  = 1'b0;
        s[B_DEAD] = 1'b0;
      end
      // wake only while running (after the run rule)
      if (msk[B_WAKE] && val[B_WAKE] && s[B_RUN]) s[B_WAKE] = 1'b1;
      // pause follows the written value
      if (msk[B_PAUSE]) s[B_PAUSE] = val[B_PAUSE];
      // flush sets status and pings the device
      if (msk[B_FLUSH] && val[B_FLUSH]) begin
        s[B_FLUSH] = 1'b1;
        flush_p    = 1'b1;
      end
      // active derivation
      if (s[B_PAUSE] || !s[B_RUN]) begin
        s[B_ACTIVE] = 1'b0;
      end else if (msk[B_RUN] || msk[B_PAUSE]) begin
        s[B_ACTIVE] = 1'b1;
      end else if (msk[B_WAKE] && val[B_WAKE]) begin
        s[B_ACTIVE] = 1'b1;
      end
    end
    if (halt) begin
      s[B_DEAD]   = 1'b1;
      s[B_ACTIVE] = 1'b0;
    end
    nxt     = s;
    start_p = ctl_we && s[B_ACTIVE];
  end
endmodule

// File: rtl/chctl_channel.sv
module chctl_channel
  import chctl_pkg::*;
#(
  parameter int REGS_PER_CH = 8,
  localparam int REG_SEL_W  = (REGS_PER_CH > 1) ? $clog2(REGS_PER_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  word_t                wdata,
  input  logic                 halt,
  output word_t                rd_word,
  output word_t                status_q,
  output logic                 flush_q,
  output logic                 start_q
);
  word_t words_q [REGS_PER_CH];
  word_t status_d;
  logic  ctl_we;
  logic  store_we;
  logic  flush_d;
  logic  start_d;

  assign ctl_we   = we && (reg_sel == REG_SEL_W'(IDX_CTRL));
  assign store_we = we && (reg_sel != REG_SEL_W'(IDX_STATUS));

  chctl_status_update u_upd (
    .cur     (status_q),
    .ctl_we  (ctl_we),
    .ctl     (wdata),
    .halt    (halt),
    .nxt     (status_d),
    .flush_p (flush_d),
    .start_p (start_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      flush_q  <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      flush_q  <= flush_d;
      start_q  <= start_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS_PER_CH; i++) words_q[i] <= '0;
    end else if (store_we) begin
      words_q[reg_sel] <= wdata;
    end
  end

  always_comb begin
    if (reg_sel == REG_SEL_W'(IDX_STATUS)) rd_word = status_q;
    else                                   rd_word = words_q[reg_sel];
  end
endmodule

// File: rtl/chctl_regblock.sv
module chctl_regblock
  import chctl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CH_SHIFT    = 8,
  parameter int NUM_CH      = 4,
  parameter int REGS_PER_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] halt_req,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic [NUM_CH-1:0] flush_req,
  output logic [NUM_CH-1:0] start_req
);
  localparam int CH_IDX_W  = ADDR_W - CH_SHIFT;
  localparam int CH_SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int REG_SEL_W = (REGS_PER_CH > 1) ? $clog2(REGS_PER_CH) : 1;

  logic [CH_IDX_W-1:0]  ch_idx;
  logic [CH_SEL_W-1:0]  ch_sel;
  logic [REG_SEL_W-1:0] reg_sel;
  logic                 ch_ok;
  logic                 reg_ok;
  word_t                ch_rd [NUM_CH];
  logic [NUM_CH*32-1:0] status_flat;

  chctl_addr_decode #(
    .ADDR_W      (ADDR_W),
    .CH_SHIFT    (CH_SHIFT),
    .NUM_CH      (NUM_CH),
    .REGS_PER_CH (REGS_PER_CH)
  ) u_dec (
    .addr    (addr),
    .ch_idx  (ch_idx),
    .ch_sel  (ch_sel),
    .reg_sel (reg_sel),
    .ch_ok   (ch_ok),
    .reg_ok  (reg_ok)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic  we_c;
    word_t st_c;
    assign we_c = wr_en && ch_ok && reg_ok && (ch_idx == CH_IDX_W'(c));
    chctl_channel #(.REGS_PER_CH(REGS_PER_CH)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .we       (we_c),
      .reg_sel  (reg_sel),
      .wdata    (wdata),
      .halt     (halt_req[c]),
      .rd_word  (ch_rd[c]),
      .status_q (st_c),
      .flush_q  (flush_req[c]),
      .start_q  (start_req[c])
    );
    assign status_flat[c*32 +: 32] = st_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= (ch_ok && reg_ok) ? ch_rd[ch_sel] : '0;
    end
  end
endmodule

// File: rtl/chctl_regblock_chk.sv
module chctl_regblock_chk
  import chctl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic                 rd_valid,
  input logic [NUM_CH*32-1:0] status_flat,
  input logic [NUM_CH-1:0]    flush_req,
  input logic [NUM_CH-1:0]    start_req
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [31:0] st;
    assign st = status_flat[c*32 +: 32];

    AST_ACTIVE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
      st[B_ACTIVE] |-> (st[B_RUN] && !st[B_PAUSE])); // R6
    AST_WAKE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
      $rose(st[B_WAKE]) |-> st[B_RUN]); // R3
    AST_DEAD_CLEAR_STOPS: assert property (@(posedge clk) disable iff (rst)
      $fell(st[B_DEAD]) |-> !st[B_RUN]); // R2
    AST_FLUSH_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
      flush_req[c] |-> st[B_FLUSH]); // R5
    AST_START_HAS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      start_req[c] |-> st[B_ACTIVE]); // R7
  end
endmodule

bind chctl_regblock chctl_regblock_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_en       (rd_en),
  .rd_valid    (rd_valid),
  .status_flat (status_flat),
  .flush_req   (flush_req),
  .start_req   (start_req)
);

// File: tb/chctl_regblock_bench.sv
`timescale 1ns/1ps
module chctl_regblock_bench;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [NCH-1:0]  halt_req = '0;
  logic [31:0]     rdata;
  logic            rd_valid;
  logic [NCH-1:0]  flush_req;
  logic [NCH-1:0]  start_req;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  chctl_regblock u_chctl_regblock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .halt_req(halt_req), .rdata(rdata), .rd_valid(rd_valid),
    .flush_req(flush_req), .start_req(start_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ad(input int ch, input int r);
    return 12'((ch << 8) | (r << 2));
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    output logic [NCH-1:0] st, output logic [NCH-1:0] fl);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    st = start_req; fl = flush_req;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    chk("R9 rd_valid", {31'b0, rd_valid}, 32'd1);
    rd_en = 1'b0;
  endtask

  task automatic ctl_step(input string req, input int ch, input logic [31:0] d,
                          input logic [31:0] exp_st, input logic exp_start,
                          input logic exp_flush);
    logic [NCH-1:0] st, fl;
    logic [31:0] v;
    wr(ad(ch, 0), d, st, fl);
    chk({req, " start_req"}, {31'b0, st[ch]}, {31'b0, exp_start});
    chk({req, " flush_req"}, {31'b0, fl[ch]}, {31'b0, exp_flush});
    rd(ad(ch, 1), v);
    chk({req, " status"}, v, exp_st);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(ad(c, 1), v);
      chk("R11 status after reset", v, 32'h0);
    end
    rd(ad(2, 3), v);
    chk("R11 storage after reset", v, 32'h0);
    chk("R11 pulses after reset", {28'b0, start_req | flush_req}, 32'h0);
  endtask

  task automatic t_run_pause_wake();
    ctl_step("R2 set run",          0, 32'h8000_8000, 32'h0000_8400, 1'b1, 1'b0);
    ctl_step("R3 wake while run",   0, 32'h1000_1000, 32'h0000_9400, 1'b1, 1'b0);
    ctl_step("R4 pause set",        0, 32'h4000_4000, 32'h0000_D000, 1'b0, 1'b0);
    ctl_step("R6 pause clear",      0, 32'h4000_0000, 32'h0000_9400, 1'b1, 1'b0);
  endtask

  task automatic t_flush();
    ctl_step("R5 flush value 0",    0, 32'h2000_0000, 32'h0000_9400, 1'b1, 1'b0);
    ctl_step("R5 flush value 1",    0, 32'h2000_2000, 32'h0000_B400, 1'b1, 1'b1);
  endtask

  task automatic t_halt_and_stop();
    logic [31:0] v;
    @(negedge clk); halt_req[0] = 1'b1;
    @(negedge clk); halt_req[0] = 1'b0;
    rd(ad(0, 1), v);
    chk("R8 halt sets dead clears active", v, 32'h0000_B800);
    ctl_step("R6 active kept low",  0, 32'h2000_2000, 32'h0000_B800, 1'b0, 1'b1);
    ctl_step("R2 clear run and dead", 0, 32'h8000_0000, 32'h0000_3000, 1'b0, 1'b0);
  endtask

  task automatic t_other_channels();
    logic [31:0] v;
    ctl_step("R3 wake without run", 1, 32'h1000_1000, 32'h0000_0000, 1'b0, 1'b0);
    ctl_step("R1 empty mask",       1, 32'h0000_FFFF, 32'h0000_0000, 1'b0, 1'b0);
    ctl_step("R3 run and wake same write", 2, 32'h9000_9000, 32'h0000_9400, 1'b1, 1'b0);
    ctl_step("R6 active kept high", 2, 32'h2000_2000, 32'h0000_B400, 1'b1, 1'b1);
    ctl_step("R6 run with pause",   3, 32'hC000_C000, 32'h0000_C000, 1'b0, 1'b0);
    rd(ad(1, 1), v);
    chk("R1 other channel untouched", v, 32'h0);
  endtask

  task automatic t_storage();
    logic [NCH-1:0] st, fl;
    logic [31:0] v;
    wr(ad(1, 2), 32'hDEAD_BEEF, st, fl);
    rd(ad(1, 2), v);
    chk("R9 storage readback", v, 32'hDEAD_BEEF);
    rd(ad(0, 0), v);
    chk("R9 control readback", v, 32'h8000_0000);
    wr(ad(1, 1), 32'hFFFF_FFFF, st, fl);
    rd(ad(1, 1), v);
    chk("R9 status write ignored", v, 32'h0);
    wr(ad(0, 7), 32'h0000_A5A5, st, fl);
    rd(ad(0, 7), v);
    chk("R10 last index", v, 32'h0000_A5A5);
  endtask

  task automatic t_decode();
    logic [NCH-1:0] st, fl;
    logic [31:0] v;
    wr(ad(5, 0), 32'h8000_8000, st, fl);
    chk("R10 channel out of range no start", {28'b0, st}, 32'h0);
    rd(ad(5, 1), v);
    chk("R10 channel out of range reads 0", v, 32'h0);
    wr(ad(0, 16), 32'h1234_5678, st, fl);
    rd(ad(0, 16), v);
    chk("R10 index out of range reads 0", v, 32'h0);
    rd(ad(0, 0), v);
    chk("R10 index out of range no alias", v, 32'h8000_0000);
    wr(ad(3, 2), 32'h5555_0000, st, fl);
    rd(ad(1, 2), v);
    chk("R10 channel select", v, 32'hDEAD_BEEF);
    rd(ad(3, 2), v);
    chk("R10 channel 3 storage", v, 32'h5555_0000);
  endtask

  task automatic t_reset_again();
    logic [31:0] v;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(ad(0, 1), v);
    chk("R11 status cleared", v, 32'h0);
    rd(ad(1, 2), v);
    chk("R11 storage cleared", v, 32'h0);
    rd(ad(3, 1), v);
    chk("R11 status ch3 cleared", v, 32'h0);
    rd(ad(0, 0), v);
    chk("R11 control cleared", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_run_pause_wake();
    t_flush();
    t_halt_and_stop();
    t_other_channels();
    t_storage();
    t_decode();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule